// File: doc/BRIEF.md
# Shifted-Operand Bitwise Logic Unit

This block is the bitwise-logic execution stage of a 64-bit integer core. It receives two source operands together with the already-separated fields of a register-form logic instruction. These fields are a width select, a two-bit operation code, a two-bit shift kind, a six-bit shift amount and an invert flag. It moves the second operand by the requested shift or rotation. It optionally complements the result of that shift. It then combines the second operand with the first by AND, OR or XOR, and can also produce a condition-flag update.

Operand reads, register write-back, instruction fetch and decoding of the whole instruction word all happen elsewhere. The unit holds its outputs in one pipeline register, qualified by a valid bit that follows the input valid one cycle later. The latency is the same for every data value. In 32-bit mode a shift amount with bit 5 set is an illegal encoding. The unit reports that case as undefined and suppresses both the result and the flag update.

Top module: `shlog_unit`

## Requirements
- R1: When `wide` is 1 the operation uses all 64 bits. When `wide` is 0 it uses only bits 31:0 of both operands, and bits 63:32 of `out_result` are 0.
- R2: `op_sel` chooses the combining function: 2'b00 is AND, 2'b01 is OR, 2'b10 is XOR and 2'b11 is AND with a flag update.
- R3: `sh_kind` chooses how the second operand is moved by `sh_amt`: 2'b00 is logical left, 2'b01 is logical right, 2'b10 is arithmetic right and 2'b11 is rotate right. Arithmetic right fills with bit 63 in 64-bit mode and with bit 31 in 32-bit mode. Rotation wraps within the active width.
- R4: A shift amount of 0 leaves the second operand unchanged for every shift kind, in both widths.
- R5: When `inv_b` is 1, the shifted second operand is bitwise complemented before it is combined with the first operand.
- R6: `out_flag_we` is 1 only for `op_sel` 2'b11 on a defined instruction. `out_flags` is {N,Z,C,V}, with N at bit 3 and V at bit 0. N is the top bit of the result at the active width. Z is 1 exactly when the active-width result is zero. C and V are 0.
- R7: When `wide` is 0 and `sh_amt[5]` is 1, `out_undef` is 1, `out_result` is 0 and `out_flag_we` is 0.
- R8: `out_valid` is `in_valid` delayed by exactly one clock. The result, flag and undefined outputs for an operation appear in that same cycle, whatever the data. Synchronous reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand (the one that is shifted) |
| wide | input | 1 | 1: 64-bit operation, 0: 32-bit operation |
| op_sel | input | 2 | Combining function select |
| sh_kind | input | 2 | Shift kind select |
| sh_amt | input | 6 | Unsigned shift amount |
| inv_b | input | 1 | Complement the shifted second operand |
| out_valid | output | 1 | Registered outputs are valid |
| out_result | output | 64 | Result, zero-extended in 32-bit mode |
| out_flag_we | output | 1 | Flag update enable |
| out_flags | output | 4 | {N,Z,C,V} flag values |
| out_undef | output | 1 | Illegal shift amount for 32-bit mode |

## Verification
The assertions assume that reset is held for at least one clock edge before the first operation. They also assume that the control inputs are stable at the sampling edge whenever `in_valid` is 1. The flag assertions rely on the registered flags being meaningful only while `out_flag_we` is set. For that reason the bench compares `out_flags` only on flag-writing operations, and it drives every input from the falling clock edge. The undefined case is driven with amounts of 32 and 63 in 32-bit mode, and with the same amounts in 64-bit mode to show that they are legal there. Operands in 32-bit tests carry nonzero upper halves, so that any leakage of those bits into the result or the flags would show.

// File: rtl/shlog_pkg.sv
package shlog_pkg;

    localparam int XLEN  = 64;
    localparam int HLEN  = XLEN / 2;
    localparam int AMT_W = $clog2(XLEN);

    typedef enum logic [1:0] {
        OP_AND  = 2'b00,
        OP_OR   = 2'b01,
        OP_XOR  = 2'b10,
        OP_ANDF = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } sh_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            flag_we;
        flags_t          flags;
        logic            undef;
        logic            wide;
    } stage_t;

    function automatic logic [XLEN-1:0] width_mask(input logic wide);
        return wide ? {XLEN{1'b1}} : {{(XLEN-HLEN){1'b0}}, {HLEN{1'b1}}};
    endfunction

endpackage

// File: rtl/shlog_shifter.sv
module shlog_shifter
    import shlog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wide,
    input  sh_e              kind,
    input  logic [AMT_W-1:0] amt,
    input  logic [XLEN-1:0]  opnd,
    output logic [XLEN-1:0]  shifted
);

    // lane 0 handles the narrow width, lane 1 the full width
    logic [XLEN-1:0] lane_out [2];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int WD = (g == 1) ? XLEN : HLEN;
        localparam int AW = $clog2(WD);

        logic [WD-1:0]   src;
        logic [AW-1:0]   sa;
        logic [2*WD-1:0] rot;
        logic [WD-1:0]   res;

        assign src = opnd[WD-1:0];
        assign sa  = amt[AW-1:0];
        assign rot = {src, src} >> sa;

        always_comb begin
            unique case (kind)
                SH_LSL:  res = src << sa;
                SH_LSR:  res = src >> sa;
                SH_ASR:  res = $signed(src) >>> sa;
                default: res = rot[WD-1:0];
            endcase
        end

        assign lane_out[g] = XLEN'(res);
    end

    assign shifted = wide ? lane_out[1] : lane_out[0];

    // R4
    zero_amt_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (amt == '0) |-> (shifted == (opnd & width_mask(wide))));

endmodule

// File: rtl/shlog_logic.sv
module shlog_logic
    import shlog_pkg::*;
(
    input  logic            wide,
    input  op_e             op,
    input  logic            inv,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b_sh,
    output logic [XLEN-1:0] res,
    output flags_t          flg,
    output logic            sets_flags
);

    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] raw;

    assign b_eff = inv ? ~b_sh : b_sh;

    always_comb begin
        unique case (op)
            OP_OR:   raw = a | b_eff;
            OP_XOR:  raw = a ^ b_eff;
            default: raw = a & b_eff;
        endcase
    end

    assign res        = raw & width_mask(wide);
    assign flg.n      = wide ? res[XLEN-1] : res[HLEN-1];
    assign flg.z      = (res == '0);
    assign flg.c      = 1'b0;
    assign flg.v      = 1'b0;
    assign sets_flags = (op == OP_ANDF);

endmodule

// File: rtl/shlog_unit.sv
module shlog_unit
    import shlog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic             wide,
    input  logic [1:0]       op_sel,
    input  logic [1:0]       sh_kind,
    input  logic [AMT_W-1:0] sh_amt,
    input  logic             inv_b,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_result,
    output logic             out_flag_we,
    output logic [3:0]       out_flags,
    output logic             out_undef
);

    logic [XLEN-1:0] b_shifted;
    logic [XLEN-1:0] comb_res;
    flags_t          comb_flg;
    logic            comb_sets;
    logic            illegal;
    stage_t          nxt;
    stage_t          q;
    logic            valid_q;

    shlog_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .wide    (wide),
        .kind    (sh_e'(sh_kind)),
        .amt     (sh_amt),
        .opnd    (src_b),
        .shifted (b_shifted)
    );

    shlog_logic u_logic (
        .wide       (wide),
        .op         (op_e'(op_sel)),
        .inv        (inv_b),
        .a          (src_a),
        .b_sh       (b_shifted),
        .res        (comb_res),
        .flg        (comb_flg),
        .sets_flags (comb_sets)
    );

    // the top amount bit is only legal at full width
    assign illegal = !wide && sh_amt[AMT_W-1];

    always_comb begin
        nxt.result  = illegal ? '0 : comb_res;
        nxt.flag_we = comb_sets && !illegal;
        nxt.flags   = illegal ? '0 : comb_flg;
        nxt.undef   = illegal;
        nxt.wide    = wide;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            q       <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                q <= nxt;
            end
        end
    end

    assign out_valid   = valid_q;
    assign out_result  = q.result;
    assign out_flag_we = q.flag_we;
    assign out_flags   = q.flags;
    assign out_undef   = q.undef;

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    undef_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide && sh_amt[AMT_W-1]) |=> out_undef);

    // R7
    undef_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_undef) |-> (out_result == '0 && !out_flag_we));

    // R6
    cv_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_flag_we) |-> (out_flags[1:0] == 2'b00));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_flag_we) |-> (out_flags[2] == (out_result == '0)));

    // R1
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !q.wide) |-> (out_result[XLEN-1:HLEN] == '0));

endmodule

// File: tb/test_shlog_unit.sv
`timescale 1ns/1ps
module test_shlog_unit;

    localparam int HALF_NS = 4;
    localparam int WDOG_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic        wide;
    logic [1:0]  op_sel;
    logic [1:0]  sh_kind;
    logic [5:0]  sh_amt;
    logic        inv_b;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_flag_we;
    logic [3:0]  out_flags;
    logic        out_undef;

    int checks = 0;
    int errors = 0;

    always #HALF_NS clk = ~clk;

    shlog_unit i_shlog_unit (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .src_a       (src_a),
        .src_b       (src_b),
        .wide        (wide),
        .op_sel      (op_sel),
        .sh_kind     (sh_kind),
        .sh_amt      (sh_amt),
        .inv_b       (inv_b),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_flag_we (out_flag_we),
        .out_flags   (out_flags),
        .out_undef   (out_undef)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // bit-level model written from the requirements
    function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                  input logic w, input logic [1:0] op,
                                  input logic [1:0] k, input logic [5:0] amt,
                                  input logic inv,
                                  output logic [63:0] r, output logic we,
                                  output logic [3:0] f, output logic u);
        int wd = w ? 64 : 32;
        int s  = w ? int'(amt) : int'(amt[4:0]);
        logic [63:0] sh = '0;
        u = !w && amt[5];
        for (int i = 0; i < wd; i++) begin
            case (k)
                2'b00:   sh[i] = (i >= s) ? b[i-s] : 1'b0;
                2'b01:   sh[i] = (i + s < wd) ? b[i+s] : 1'b0;
                2'b10:   sh[i] = (i + s < wd) ? b[i+s] : b[wd-1];
                default: sh[i] = b[(i+s) % wd];
            endcase
        end
        if (inv) sh = ~sh;
        case (op)
            2'b01:   r = a | sh;
            2'b10:   r = a ^ sh;
            default: r = a & sh;
        endcase
        if (!w) r[63:32] = '0;
        if (u) begin
            r = '0; we = 1'b0; f = '0;
        end else begin
            we = (op == 2'b11);
            f  = {r[wd-1], (r == '0), 2'b00};
        end
    endfunction

    task automatic drive(input logic [63:0] a, input logic [63:0] b,
                         input logic w, input logic [1:0] op,
                         input logic [1:0] k, input logic [5:0] amt,
                         input logic inv);
        in_valid = 1'b1; src_a = a; src_b = b; wide = w;
        op_sel = op; sh_kind = k; sh_amt = amt; inv_b = inv;
    endtask

    task automatic compare(input string req, input logic [63:0] a, input logic [63:0] b,
                           input logic w, input logic [1:0] op,
                           input logic [1:0] k, input logic [5:0] amt,
                           input logic inv);
        logic [63:0] er;
        logic        ewe;
        logic [3:0]  ef;
        logic        eu;
        model(a, b, w, op, k, amt, inv, er, ewe, ef, eu);
        check("R8", {req, " valid"}, 64'(out_valid), 64'd1);
        check(req, "undef", 64'(out_undef), 64'(eu));
        check(req, "result", out_result, er);
        check(req, "flag_we", 64'(out_flag_we), 64'(ewe));
        if (ewe) check(req, "flags", 64'(out_flags), 64'(ef));
    endtask

    // one operation: drive at a falling edge, check at the next falling edge
    task automatic run_op(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic w, input logic [1:0] op,
                          input logic [1:0] k, input logic [5:0] amt,
                          input logic inv);
        drive(a, b, w, op, k, amt, inv);
        @(negedge clk);
        in_valid = 1'b0;
        compare(req, a, b, w, op, k, amt, inv);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b1;
        src_a = '1; src_b = '1; wide = 1'b1; op_sel = 2'b11;
        sh_kind = 2'b00; sh_amt = '0; inv_b = 1'b0;
        repeat (3) @(negedge clk);
        check("R8", "valid during reset", 64'(out_valid), 64'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R8", "valid after reset", 64'(out_valid), 64'd0);
    endtask

    task automatic t_ops;
        for (int op = 0; op < 4; op++) begin
            run_op("R2", 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_A5A5, 1'b1,
                   2'(op), 2'b00, 6'd0, 1'b0);
            run_op("R2", 64'hFFFF_0000_AAAA_5555, 64'h1234_5678_9ABC_DEF0, 1'b1,
                   2'(op), 2'b01, 6'd8, 1'b0);
        end
    endtask

    task automatic t_shifts;
        logic [5:0] amts [4] = '{6'd4, 6'd63, 6'd1, 6'd33};
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < 4; j++) begin
                run_op("R3", 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0001_8000_0003, 1'b1,
                       2'b00, 2'(k), amts[j], 1'b0);
            end
            run_op("R3", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_8000_0003, 1'b0,
                   2'b00, 2'(k), 6'd31, 1'b0);
            run_op("R3", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_8000_0003, 1'b0,
                   2'b01, 2'(k), 6'd7, 1'b0);
        end
    endtask

    task automatic t_zero_amt;
        for (int k = 0; k < 4; k++) begin
            run_op("R4", 64'h0, 64'h9ABC_DEF0_8765_4321, 1'b1, 2'b01, 2'(k), 6'd0, 1'b0);
            run_op("R4", 64'h0, 64'h9ABC_DEF0_8765_4321, 1'b0, 2'b01, 2'(k), 6'd0, 1'b0);
        end
    endtask

    task automatic t_invert;
        for (int op = 0; op < 4; op++) begin
            run_op("R5", 64'hA5A5_5A5A_F00F_0FF0, 64'h3C3C_C3C3_1234_8765, 1'b1,
                   2'(op), 2'b11, 6'd12, 1'b1);
            run_op("R5", 64'hA5A5_5A5A_F00F_0FF0, 64'h3C3C_C3C3_1234_8765, 1'b0,
                   2'(op), 2'b10, 6'd3, 1'b1);
        end
    endtask

    task automatic t_flags;
        run_op("R6", 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'b11, 2'b00, 6'd0, 1'b0);
        run_op("R6", 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 1'b1,
               2'b11, 2'b00, 6'd0, 1'b0);
        run_op("R6", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_8000_0000, 1'b0,
               2'b11, 2'b00, 6'd0, 1'b0);
        run_op("R6", 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0,
               2'b11, 2'b00, 6'd0, 1'b0);
        run_op("R6", 64'h7, 64'h1, 1'b1, 2'b11, 2'b00, 6'd63, 1'b1);
    endtask

    task automatic t_undef;
        run_op("R7", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 1'b0,
               2'b11, 2'b00, 6'd32, 1'b0);
        run_op("R7", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 1'b0,
               2'b01, 2'b11, 6'd63, 1'b1);
        run_op("R7", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 1'b1,
               2'b11, 2'b00, 6'd32, 1'b0);
        run_op("R7", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 1'b1,
               2'b01, 2'b11, 6'd63, 1'b0);
    endtask

    task automatic t_narrow;
        run_op("R1", 64'hDEAD_BEEF_0000_FFFF, 64'hCAFE_F00D_FFFF_0000, 1'b0,
               2'b01, 2'b00, 6'd0, 1'b0);
        run_op("R1", 64'hDEAD_BEEF_0000_FFFF, 64'hCAFE_F00D_FFFF_0000, 1'b0,
               2'b10, 2'b00, 6'd0, 1'b1);
        run_op("R1", 64'hDEAD_BEEF_0000_FFFF, 64'hCAFE_F00D_FFFF_0000, 1'b1,
               2'b10, 2'b00, 6'd0, 1'b1);
    endtask

    task automatic t_stream;
        logic [63:0] av [4] = '{64'h1, 64'hFFFF_0000_FFFF_0000, 64'h0, 64'h8000_0000_0000_0000};
        logic [63:0] bv [4] = '{64'h3, 64'h0F0F_0F0F_0F0F_0F0F, 64'h5, 64'hFFFF_FFFF_FFFF_FFFF};
        logic [63:0] pa = '0, pb = '0;
        logic [1:0]  pop = '0, pk = '0;
        logic [5:0]  pamt = '0;
        for (int i = 0; i < 4; i++) begin
            drive(av[i], bv[i], 1'b1, 2'(i), 2'(3 - i), 6'(i * 5), 1'(i));
            if (i > 0) compare("R8", pa, pb, 1'b1, pop, pk, pamt, 1'(i - 1));
            pa = av[i]; pb = bv[i]; pop = 2'(i); pk = 2'(3 - i); pamt = 6'(i * 5);
            @(negedge clk);
        end
        in_valid = 1'b0;
        compare("R8", pa, pb, 1'b1, pop, pk, pamt, 1'b1);
        @(negedge clk);
        check("R8", "valid after idle", 64'(out_valid), 64'd0);
    endtask

    initial begin
        t_reset();
        t_ops();
        t_shifts();
        t_zero_amt();
        t_invert();
        t_flags();
        t_undef();
        t_narrow();
        t_stream();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule